// File: doc/BRIEF.md
# Stereo Limiter Gain Controller

This block watches a stereo pair of signed samples and pulls down one shared volume code whenever either channel is too loud. Both channels share that code, so the stereo image does not shift when only one side peaks. The controller takes samples from either the record pair or the playback pair. It picks the pair from the converter power bits. When any ADC channel is powered it uses the record pair, even if the DAC is also on. When only the DAC is powered it uses the playback pair.

Each sample is marked with a one-cycle strobe. A magnitude above the selected threshold raises an attenuation request. In gated mode the request waits for a sign change on either channel, or for a timeout counted in samples, and then removes 1, 2, 4 or 8 gain steps. In ungated mode each loud sample removes exactly one step at once, whatever the step select says. Raising the gain again is handled outside this block.

Top module: `stereo_limiter_ctrl`

## Requirements
- R1: Path selection.
  - `path_rec` is 1 whenever any bit of `adc_on` is 1.
  - `path_play` is 1 only when `adc_on` is all zero and `dac_on` is 1.
  - Neither output is 1 when nothing is powered. The two are never 1 together.
  - The controller acts only on the sample pair of the selected path.
- R2: While `lim_en` is 0 the gain code does not change. Any pending request, the timeout count and the previous-sample sign memory are all cleared.
- R3: A channel is over threshold when its magnitude is strictly greater than the constant for `thr_sel`:
  - 00 gives 24573.
  - 01 gives 20437.
  - 10 gives 16422.
  - 11 gives 12314.
  - A magnitude equal to the constant does not trigger. The magnitude of -32768 is 32768.
- R4: The left and right channels each raise a request on their own, and both act on the one shared gain code.
- R5: With `zc_en`=1 an applied request lowers the gain by 1, 2, 4 or 8 for `att_sel` = 0, 1, 2 or 3.
- R6: With `zc_en`=0 every strobed over-threshold sample lowers the gain by exactly 1, on the clock edge of that sample, for any `att_sel`.
- R7: With `zc_en`=1 a pending request is applied on the first strobed sample where bit 15 of either channel differs from that channel's previous strobed sample. A sample is only a previous sample if it was taken since the controller was last enabled on the current path.
- R8: Timeout with `zc_en`=1.
  - With no crossing, a request is applied on the N-th consecutive strobed sample counted from the sample that raised it, where N = 128 << `tmo_sel`.
  - The count restarts after every applied update.
- R9: The gain code saturates at 0 and never wraps. It never rises.
- R10: Reset sets the gain code to 200 and clears all request state.
- R11: The gain code does not change when `smp_valid` is 0 or when neither path is selected.
- R12: A request lowers the gain only once. Further over-threshold samples while that request is still pending add no steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| rec_l | input | 16 | Record path left sample, two's complement |
| rec_r | input | 16 | Record path right sample, two's complement |
| play_l | input | 16 | Playback path left sample, two's complement |
| play_r | input | 16 | Playback path right sample, two's complement |
| adc_on | input | 2 | Per-channel ADC power bits |
| dac_on | input | 1 | DAC power bit |
| lim_en | input | 1 | Limiter enable |
| thr_sel | input | 2 | Detection threshold select |
| att_sel | input | 2 | Attenuation step select (gated mode) |
| zc_en | input | 1 | 1 = gate updates on zero crossing or timeout |
| tmo_sel | input | 2 | Zero-crossing timeout select |
| gain_code | output | 8 | Shared gain code for both channels |
| path_rec | output | 1 | Record path selected |
| path_play | output | 1 | Playback path selected |

## Verification
The ungated mode is swept across all four threshold codes. For each code the bench sends samples at exactly the threshold and one count above it, with both signs and on each channel. This separates a strict compare from an inclusive one, catches a faulty absolute value, and catches a channel that is missed.

Gated mode is tried with each step size. Each trial is a loud sample, a second loud sample of the same sign, and then a sign flip on only one channel. This shows whether updates wait for a crossing, whether repeated loud samples add steps, and whether either channel's crossing is enough.

Steady loud samples with no crossing are run for every timeout select, and twice for the shortest one. This pins the exact sample on which the timeout fires and shows that the count restarts. Further runs check power-bit combinations, disabling while a request is pending, and a long run down to zero.

// File: rtl/limiter_pkg.sv
package limiter_pkg;

    typedef enum logic [1:0] {
        PATH_NONE = 2'd0,
        PATH_PLAY = 2'd1,
        PATH_REC  = 2'd2
    } path_e;

    // Magnitude limits for a 16-bit full scale, one per threshold code.
    function automatic logic [15:0] thr_q15(input logic [1:0] code);
        case (code)
            2'd0:    return 16'd24573;
            2'd1:    return 16'd20437;
            2'd2:    return 16'd16422;
            default: return 16'd12314;
        endcase
    endfunction

endpackage

// File: rtl/limiter_path_sel.sv
module limiter_path_sel
    import limiter_pkg::*;
#(
    parameter int SW   = 16,
    parameter int NADC = 2,
    parameter int NCH  = 2
) (
    input  logic [NADC-1:0]        adc_on,
    input  logic                   dac_on,
    input  logic [NCH-1:0][SW-1:0] rec_smp,
    input  logic [NCH-1:0][SW-1:0] play_smp,
    output path_e                  path,
    output logic [NCH-1:0][SW-1:0] smp
);

    always_comb begin
        if (|adc_on) begin
            path = PATH_REC;
        end else if (dac_on) begin
            path = PATH_PLAY;
        end else begin
            path = PATH_NONE;
        end
    end

    assign smp = (path == PATH_PLAY) ? play_smp : rec_smp;

endmodule

// File: rtl/limiter_level_det.sv
module limiter_level_det #(
    parameter int SW  = 16,
    parameter int NCH = 2
) (
    input  logic [NCH-1:0][SW-1:0] smp,
    input  logic [SW:0]            thr,
    output logic [NCH-1:0]         over,
    output logic [NCH-1:0]         sgn
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SW:0] ext;
        logic [SW:0] mag;

        assign ext     = {smp[c][SW-1], smp[c]};
        assign mag     = smp[c][SW-1] ? (~ext + 1'b1) : ext;
        assign over[c] = (mag > thr);
        assign sgn[c]  = smp[c][SW-1];
    end

endmodule

// File: rtl/limiter_ctrl_dec.sv
module limiter_ctrl_dec #(
    parameter int GW       = 8,
    parameter int TMO_BASE = 128,
    parameter int CW       = 10
) (
    input  logic [1:0]    att_sel,
    input  logic          zc_en,
    input  logic [1:0]    tmo_sel,
    output logic [GW-1:0] step,
    output logic [CW-1:0] tmo_last
);

    // Immediate mode always uses a single step.
    assign step     = zc_en ? (GW'(1) << att_sel) : GW'(1);
    assign tmo_last = CW'((TMO_BASE << tmo_sel) - 1);

endmodule

// File: rtl/stereo_limiter_ctrl.sv
module stereo_limiter_ctrl
    import limiter_pkg::*;
#(
    parameter int SW       = 16,
    parameter int GW       = 8,
    parameter int NADC     = 2,
    parameter int TMO_BASE = 128,
    parameter int GAIN_RST = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [SW-1:0]   rec_l,
    input  logic [SW-1:0]   rec_r,
    input  logic [SW-1:0]   play_l,
    input  logic [SW-1:0]   play_r,
    input  logic [NADC-1:0] adc_on,
    input  logic            dac_on,
    input  logic            lim_en,
    input  logic [1:0]      thr_sel,
    input  logic [1:0]      att_sel,
    input  logic            zc_en,
    input  logic [1:0]      tmo_sel,
    output logic [GW-1:0]   gain_code,
    output logic            path_rec,
    output logic            path_play
);

    localparam int NCH       = 2;
    localparam int CW        = $clog2(TMO_BASE * 8);
    localparam int THR_SHIFT = SW - 16;

    typedef struct packed {
        logic [GW-1:0]  gain;
        path_e          path;
        logic           have_prev;
        logic [NCH-1:0] sgn;
        logic           pend;
        logic [CW-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    path_e                  path;
    logic [NCH-1:0][SW-1:0] smp;
    logic [NCH-1:0]         over;
    logic [NCH-1:0]         sgn;
    logic [SW:0]            thr_mag;
    logic [GW-1:0]          step;
    logic [CW-1:0]          tmo_last;

    limiter_path_sel #(.SW(SW), .NADC(NADC), .NCH(NCH)) u_path (
        .adc_on   (adc_on),
        .dac_on   (dac_on),
        .rec_smp  ({rec_r, rec_l}),
        .play_smp ({play_r, play_l}),
        .path     (path),
        .smp      (smp)
    );

    assign thr_mag = (SW+1)'({1'b0, thr_q15(thr_sel)}) << THR_SHIFT;

    limiter_level_det #(.SW(SW), .NCH(NCH)) u_det (
        .smp  (smp),
        .thr  (thr_mag),
        .over (over),
        .sgn  (sgn)
    );

    limiter_ctrl_dec #(.GW(GW), .TMO_BASE(TMO_BASE), .CW(CW)) u_dec (
        .att_sel  (att_sel),
        .zc_en    (zc_en),
        .tmo_sel  (tmo_sel),
        .step     (step),
        .tmo_last (tmo_last)
    );

    logic          active;
    logic          same_path;
    logic          prev_ok;
    logic          pend_in;
    logic [CW-1:0] cnt_in;
    logic          zc_hit;
    logic          any_over;
    logic [GW-1:0] gain_dn;

    always_comb begin
        active    = lim_en && (path != PATH_NONE);
        same_path = (path == st_q.path);
        prev_ok   = st_q.have_prev && same_path;
        pend_in   = st_q.pend && same_path;
        cnt_in    = same_path ? st_q.cnt : '0;
        zc_hit    = prev_ok && |(sgn ^ st_q.sgn);
        any_over  = |over;
        gain_dn   = (st_q.gain > step) ? (st_q.gain - step) : '0;

        st_d      = st_q;
        st_d.path = path;

        if (!active) begin
            st_d.pend      = 1'b0;
            st_d.cnt       = '0;
            st_d.have_prev = 1'b0;
        end else if (smp_valid) begin
            st_d.sgn       = sgn;
            st_d.have_prev = 1'b1;
            if (!zc_en) begin
                st_d.pend = 1'b0;
                st_d.cnt  = '0;
                if (any_over) begin
                    st_d.gain = gain_dn;
                end
            end else if (any_over || pend_in) begin
                if (zc_hit || (cnt_in == tmo_last)) begin
                    st_d.gain = gain_dn;
                    st_d.pend = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.pend = 1'b1;
                    st_d.cnt  = cnt_in + 1'b1;
                end
            end else begin
                st_d.pend = 1'b0;
                st_d.cnt  = '0;
            end
        end else if (!same_path) begin
            st_d.pend      = 1'b0;
            st_d.cnt       = '0;
            st_d.have_prev = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gain      <= GW'(GAIN_RST);
            st_q.path      <= PATH_NONE;
            st_q.have_prev <= 1'b0;
            st_q.sgn       <= '0;
            st_q.pend      <= 1'b0;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_code = st_q.gain;
    assign path_rec  = (path == PATH_REC);
    assign path_play = (path == PATH_PLAY);

endmodule

// File: rtl/limiter_checker.sv
module limiter_checker #(
    parameter int GW   = 8,
    parameter int NADC = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            smp_valid,
    input logic [NADC-1:0] adc_on,
    input logic            dac_on,
    input logic            lim_en,
    input logic            zc_en,
    input logic [GW-1:0]   gain_code,
    input logic            path_rec,
    input logic            path_play
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    a_r1_path_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({path_rec, path_play}));

    a_r1_rec_when_adc: assert property (@(posedge clk) disable iff (!rst_n)
        (|adc_on) |-> path_rec);

    a_r1_play_dac_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|adc_on) && dac_on) |-> path_play);

    a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(lim_en)) |-> (gain_code == $past(gain_code)));

    a_r11_hold_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(smp_valid)) |-> (gain_code == $past(gain_code)));

    a_r11_hold_no_path: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(path_rec) && !$past(path_play)) |-> (gain_code == $past(gain_code)));

    a_r9_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (gain_code <= $past(gain_code)));

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(zc_en)) |-> (($past(gain_code) - gain_code) <= GW'(1)));

    a_r5_step_cap: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(gain_code) - gain_code) <= GW'(8)));

endmodule

bind stereo_limiter_ctrl limiter_checker #(.GW(GW), .NADC(NADC)) u_chk (.*);

// File: tb/stereo_limiter_ctrl_test.sv
module stereo_limiter_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] rec_l = '0, rec_r = '0, play_l = '0, play_r = '0;
    logic [1:0]  adc_on = 2'b01;
    logic        dac_on = 1'b0;
    logic        lim_en = 1'b1;
    logic [1:0]  thr_sel = 2'd0, att_sel = 2'd0, tmo_sel = 2'd0;
    logic        zc_en = 1'b0;
    logic [7:0]  gain_code;
    logic        path_rec, path_play;

    int total = 0;
    int fails = 0;
    int exp_gain = 200;

    always #10 clk = ~clk;

    stereo_limiter_ctrl uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .rec_l(rec_l), .rec_r(rec_r), .play_l(play_l), .play_r(play_r),
        .adc_on(adc_on), .dac_on(dac_on), .lim_en(lim_en),
        .thr_sel(thr_sel), .att_sel(att_sel), .zc_en(zc_en), .tmo_sel(tmo_sel),
        .gain_code(gain_code), .path_rec(path_rec), .path_play(path_play)
    );

    function automatic int thr_of(input int code);
        case (code)
            0: return 24573;
            1: return 20437;
            2: return 16422;
            default: return 12314;
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic send2(input int rl, input int rr, input int pl, input int pr);
        @(negedge clk);
        rec_l = 16'(rl); rec_r = 16'(rr); play_l = 16'(pl); play_r = 16'(pr);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send(input int l, input int r);
        send2(l, r, l, r);
    endtask

    task automatic rearm();
        @(negedge clk);
        lim_en = 1'b0;
        @(negedge clk);
        lim_en = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_gain = 200;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        do_reset();
        check(gain_code, 200, "R10 reset gain");
        check(path_rec, 1, "R1 rec path after reset");

        // R1: sweep the power bits
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 2; d++) begin
                @(negedge clk);
                adc_on = 2'(a); dac_on = 1'(d);
                #1;
                check(path_rec, (a != 0) ? 1 : 0, "R1 path_rec");
                check(path_play, (a == 0 && d == 1) ? 1 : 0, "R1 path_play");
            end
        end

        // R11: nothing powered
        @(negedge clk); adc_on = 2'b00; dac_on = 1'b0;
        send(32767, 32767);
        check(gain_code, exp_gain, "R11 no path no change");

        // R1: playback path uses the playback pair only
        @(negedge clk); dac_on = 1'b1;
        send2(32767, 32767, 100, 100);
        check(gain_code, exp_gain, "R1 play path ignores rec pair");
        send2(100, 100, 32767, 100);
        exp_gain -= 1;
        check(gain_code, exp_gain, "R1 play path acts on play pair");
        @(negedge clk); adc_on = 2'b10;
        send2(100, 100, 32767, 32767);
        check(gain_code, exp_gain, "R1 rec path wins over dac");

        // R3/R4: threshold sweep, immediate mode
        @(negedge clk); adc_on = 2'b01; dac_on = 1'b0;
        for (int t = 0; t < 4; t++) begin
            int th;
            th = thr_of(t);
            @(negedge clk); thr_sel = 2'(t);
            send(th, 0);
            check(gain_code, exp_gain, "R3 equal does not trigger");
            send(0, th + 1);
            exp_gain -= 1;
            check(gain_code, exp_gain, "R4 right channel over");
            send(-(th + 1), 0);
            exp_gain -= 1;
            check(gain_code, exp_gain, "R3 negative over");
            send(0, -th);
            check(gain_code, exp_gain, "R3 negative equal");
        end

        // R6: immediate mode ignores att_sel
        @(negedge clk); thr_sel = 2'd0; att_sel = 2'd3;
        send(32767, 0);
        exp_gain -= 1;
        check(gain_code, exp_gain, "R6 single step");

        // R11: strobe low
        @(negedge clk); rec_l = 16'd32767; rec_r = 16'd32767;
        repeat (5) @(negedge clk);
        check(gain_code, exp_gain, "R11 no strobe no change");

        // R5/R7/R12: gated mode per step size
        @(negedge clk); zc_en = 1'b1;
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); att_sel = 2'(a);
            rearm();
            send(100, 100);
            check(gain_code, exp_gain, "R7 quiet sample");
            send(30000, 100);
            check(gain_code, exp_gain, "R7 waits for crossing");
            send(30000, 0);
            check(gain_code, exp_gain, "R12 no extra step");
            if (a % 2 == 0) send(100, -5);
            else send(-5, 100);
            exp_gain -= (1 << a);
            check(gain_code, exp_gain, "R5 step at crossing");
        end

        // R8: timeout per select
        @(negedge clk); att_sel = 2'd0;
        for (int ts = 0; ts < 4; ts++) begin
            int n;
            n = 128 << ts;
            @(negedge clk); tmo_sel = 2'(ts);
            rearm();
            repeat (n - 1) send(30000, 30000);
            check(gain_code, exp_gain, "R8 before timeout");
            send(30000, 30000);
            exp_gain -= 1;
            check(gain_code, exp_gain, "R8 at timeout");
            if (ts == 0) begin
                repeat (n - 1) send(30000, 30000);
                check(gain_code, exp_gain, "R8 restart before");
                send(30000, 30000);
                exp_gain -= 1;
                check(gain_code, exp_gain, "R8 restart at timeout");
            end
        end

        // R2: disable freezes and clears
        @(negedge clk); tmo_sel = 2'd3;
        rearm();
        send(100, 100);
        send(30000, 100);
        @(negedge clk); lim_en = 1'b0;
        send(-100, -100);
        check(gain_code, exp_gain, "R2 frozen while off");
        @(negedge clk); lim_en = 1'b1;
        send(-100, -100);
        check(gain_code, exp_gain, "R2 sign memory cleared");
        send(100, 100);
        check(gain_code, exp_gain, "R2 pending cleared");
        @(negedge clk); zc_en = 1'b0; lim_en = 1'b0;
        send(32767, 32767);
        check(gain_code, exp_gain, "R2 off in immediate mode");
        @(negedge clk); lim_en = 1'b1;

        // R9/R10: run down to zero
        do_reset();
        check(gain_code, 200, "R10 gain after second reset");
        for (int i = 0; i < 205; i++) begin
            send(-32768, 0);
            exp_gain = (exp_gain > 0) ? exp_gain - 1 : 0;
            check(gain_code, exp_gain, "R9 saturating descent");
        end

        report();
        $finish;
    end

endmodule